// File: doc/BRIEF.md
# Strided Interleaved Vector Memory Loader

This block loads one vector of words from a memory split into independently busy banks. Software-visible setup is not part of it: a requester offers a start address, a stride and an element count through a start/ready handshake, and the loader then walks the address sequence, sending at most one request per cycle onto an address bus that all banks share. The bank is picked by the low address bits, so consecutive words fall in consecutive banks.

Each bank stays occupied for a fixed number of cycles after it takes a request and answers on a shared return bus exactly that many cycles later. The loader keeps one occupancy counter per bank and holds back the next request while its target bank is still occupied. A unit stride over enough banks therefore streams one element per cycle, whereas strides that revisit a bank too soon insert stall cycles. Because every access takes the same time, data comes back in request order and is written into a vector buffer slot by slot. A one-cycle completion pulse follows the last write, and the buffer can then be read through an index port.

Top module: `vec_load_unit`

## Requirements
- R1: Out of reset the loader is idle: ready_o is 1, mem_req_o is 0 and done_o is 0.
- R2: A load is accepted at a clock edge where start_i and ready_o are both 1; ready_o is 0 from the next cycle until the load completes, and start_i is ignored while ready_o is 0.
- R3: Element k is requested at address base + k*stride, computed modulo 2^ADDR_W, and elements are requested strictly in index order.
- R4: The bank of an address is its low log2(NUM_BANKS) bits (bits 3:0 by default); after a request to a bank, no further request goes to that bank for BANK_LAT (11) cycles.
- R5: The next element is requested in the first cycle in which the loader is busy and its bank is free, the earliest being the cycle after acceptance; with stride 1 and 16 banks one element is requested every cycle.
- R6: The word on mem_rdata_i in the cycle mem_rvalid_i is 1 is stored into the next slot in element order; after completion rd_data_o shows slot rd_idx_i combinationally.
- R7: done_o is 1 for exactly one cycle, the cycle after the final element's return, and ready_o is 1 in that same cycle.
- R8: A length of 0 or above MAX_VLEN (64) loads MAX_VLEN elements; lengths 1 to 64 load that many.
- R9: A stride of 0 requests the same address repeatedly, one request every BANK_LAT cycles.
- R10: Addresses that pass the top of the address space wrap to its bottom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a load |
| ready_o | output | 1 | Loader idle, start_i will be taken |
| base_i | input | ADDR_W | First element word address |
| stride_i | input | ADDR_W | Address step between elements |
| vlen_i | input | $clog2(MAX_VLEN+1) | Element count (0 or above MAX_VLEN means MAX_VLEN) |
| mem_req_o | output | 1 | Request valid on the shared address bus |
| mem_addr_o | output | ADDR_W | Word address of the request |
| mem_rvalid_i | input | 1 | Return word valid on the shared data bus |
| mem_rdata_i | input | DATA_W | Returned word |
| done_o | output | 1 | One-cycle completion pulse |
| rd_idx_i | input | $clog2(MAX_VLEN) | Buffer slot to read |
| rd_data_o | output | DATA_W | Contents of the selected slot |

## Verification
A wrong bank occupancy count shows at the ports in the very cycle it matters: a request appears on mem_req_o one or more cycles early or late, which a cycle-exact model of bank timing flags at once. A corrupted address accumulator shows on mem_addr_o at the next request. A write pointer that drifts or a wrong captured length surfaces as a done_o pulse in the wrong cycle, or only after completion as a wrong word read back from a buffer slot.

// File: rtl/vlu_pkg.sv
package vlu_pkg;
  typedef enum logic [0:0] {
    VLU_IDLE = 1'b0,
    VLU_RUN  = 1'b1
  } vlu_state_e;
endpackage

// File: rtl/vlu_addr_gen.sv
module vlu_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              issue_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pending_o
);
  logic [ADDR_W-1:0] addr_q, stride_q;
  logic [LEN_W-1:0]  len_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      stride_q <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
    end else if (load_i) begin
      addr_q   <= base_i;
      stride_q <= stride_i;
      len_q    <= len_i;
      cnt_q    <= '0;
    end else if (issue_i) begin
      addr_q <= addr_q + stride_q;  // wraps modulo 2^ADDR_W
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign addr_o    = addr_q;
  assign pending_o = (cnt_q != len_q);
endmodule

// File: rtl/vlu_bank_tracker.sv
module vlu_bank_tracker #(
  parameter int NUM_BANKS = 16,
  parameter int BANK_LAT  = 11,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              free_o
);
  localparam int CNT_W = $clog2(BANK_LAT + 1);

  logic [NUM_BANKS-1:0] free_vec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cnt_q <= '0;
      else if (issue_i && bank_i == BANK_W'(b))
        cnt_q <= CNT_W'(BANK_LAT - 1);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
    assign free_vec[b] = (cnt_q == '0);
  end

  assign free_o = free_vec[bank_i];
endmodule

// File: rtl/vlu_collect.sv
module vlu_collect
  import vlu_pkg::*;
#(
  parameter int MAX_VLEN = 64,
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 7,
  localparam int IDX_W   = $clog2(MAX_VLEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              rvalid_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o
);
  vlu_state_e        state_q;
  logic [LEN_W-1:0]  wr_ptr_q, len_q;
  logic              done_q;
  logic [DATA_W-1:0] vreg_q [MAX_VLEN];
  logic              wr_en;

  assign wr_en = (state_q == VLU_RUN) && rvalid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= VLU_IDLE;
      wr_ptr_q <= '0;
      len_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        state_q  <= VLU_RUN;
        wr_ptr_q <= '0;
        len_q    <= len_i;
      end else if (wr_en) begin
        wr_ptr_q <= wr_ptr_q + 1'b1;
        if (wr_ptr_q == len_q - LEN_W'(1)) begin
          state_q <= VLU_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) vreg_q[wr_ptr_q[IDX_W-1:0]] <= rdata_i;
  end

  assign busy_o    = (state_q == VLU_RUN);
  assign done_o    = done_q;
  assign rd_data_o = vreg_q[rd_idx_i];
endmodule

// File: rtl/vec_load_unit.sv
module vec_load_unit #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 16,
  parameter int BANK_LAT  = 11,
  parameter int MAX_VLEN  = 64,
  localparam int LEN_W    = $clog2(MAX_VLEN + 1),
  localparam int IDX_W    = $clog2(MAX_VLEN),
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              ready_o,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [LEN_W-1:0]  vlen_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              accept, busy, pending, bank_free, issue;
  logic [LEN_W-1:0]  eff_len;
  logic [ADDR_W-1:0] cur_addr;

  assign ready_o = !busy;
  assign accept  = start_i && ready_o;
  assign eff_len = (vlen_i == '0 || vlen_i > LEN_W'(MAX_VLEN)) ? LEN_W'(MAX_VLEN) : vlen_i;
  assign issue   = busy && pending && bank_free;

  vlu_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_agen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .base_i    (base_i),
    .stride_i  (stride_i),
    .len_i     (eff_len),
    .issue_i   (issue),
    .addr_o    (cur_addr),
    .pending_o (pending)
  );

  vlu_bank_tracker #(.NUM_BANKS(NUM_BANKS), .BANK_LAT(BANK_LAT)) u_banks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .bank_i  (cur_addr[BANK_W-1:0]),
    .free_o  (bank_free)
  );

  vlu_collect #(.MAX_VLEN(MAX_VLEN), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_coll (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .len_i     (eff_len),
    .rvalid_i  (mem_rvalid_i),
    .rdata_i   (mem_rdata_i),
    .rd_idx_i  (rd_idx_i),
    .busy_o    (busy),
    .done_o    (done_o),
    .rd_data_o (rd_data_o)
  );

  assign mem_req_o  = issue;
  assign mem_addr_o = cur_addr;
endmodule

// File: rtl/vlu_checker.sv
module vlu_checker #(
  parameter int ADDR_W    = 16,
  parameter int NUM_BANKS = 16,
  parameter int BANK_LAT  = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ready_o,
  input logic [ADDR_W-1:0] base_i,
  input logic [ADDR_W-1:0] stride_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              done_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int CNT_W  = $clog2(BANK_LAT + 1);

  logic [ADDR_W-1:0] exp_addr_q, step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_addr_q <= '0;
      step_q     <= '0;
    end else if (start_i && ready_o) begin
      exp_addr_q <= base_i;
      step_q     <= stride_i;
    end else if (mem_req_o) begin
      exp_addr_q <= exp_addr_q + step_q;
    end
  end

  a_r3_addr_sequence: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o == exp_addr_q);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o);

  a_r2_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> !ready_o);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gap
    logic [CNT_W-1:0] gap_q;
    logic             hit;
    assign hit = mem_req_o && (mem_addr_o[BANK_W-1:0] == BANK_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        gap_q <= '0;
      else if (hit)       gap_q <= CNT_W'(BANK_LAT - 1);
      else if (gap_q != '0) gap_q <= gap_q - 1'b1;
    end
    a_r4_bank_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |-> gap_q == '0);
  end
endmodule

bind vec_load_unit vlu_checker #(
  .ADDR_W   (ADDR_W),
  .NUM_BANKS(NUM_BANKS),
  .BANK_LAT (BANK_LAT)
) u_vlu_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .ready_o   (ready_o),
  .base_i    (base_i),
  .stride_i  (stride_i),
  .mem_req_o (mem_req_o),
  .mem_addr_o(mem_addr_o),
  .done_o    (done_o)
);

// File: tb/vec_load_unit_test.sv
module vec_load_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 11;
  localparam int MAXV = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] base = '0, stride = '0;
  logic [6:0]  vlen = '0;
  logic [5:0]  rd_idx = '0;
  logic        rvalid = 1'b0;
  logic [31:0] rdata = '0;
  logic        ready, req, done;
  logic [15:0] maddr;
  logic [31:0] rd_data;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_load_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ready_o(ready),
    .base_i(base), .stride_i(stride), .vlen_i(vlen),
    .mem_req_o(req), .mem_addr_o(maddr), .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .done_o(done), .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  function automatic logic [31:0] word_of(input logic [15:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // behavioural reference state
  int          cyc = 0;
  bit          m_busy = 0, m_done_exp = 0, done_next = 0;
  logic [15:0] m_addr, m_stride;
  int          m_len = 0, m_issued = 0, m_returned = 0;
  int          bank_free[16];
  logic [31:0] exp_data[MAXV];
  int          ret_cyc[$];
  logic [15:0] ret_addr[$];

  always @(negedge clk) begin
    if (rst_n) begin
      bit m_req;
      cyc++;
      m_done_exp = done_next;
      if (done_next) m_busy = 0;
      done_next = 0;
      chk(ready, !m_busy, "R2 ready level");
      chk(done, m_done_exp, "R7 done pulse");
      m_req = m_busy && (m_issued < m_len) && (bank_free[m_addr[3:0]] <= cyc);
      chk(req, m_req, "R5 request timing");
      if (m_req && req) chk(maddr, m_addr, "R3 request address");
      if (m_req) begin
        exp_data[m_issued] = word_of(m_addr);
        bank_free[m_addr[3:0]] = cyc + LAT;
        m_addr = m_addr + m_stride;
        m_issued++;
      end
      if (req) begin
        ret_cyc.push_back(cyc + LAT);
        ret_addr.push_back(maddr);
      end
      if (ret_cyc.size() > 0 && ret_cyc[0] == cyc) begin
        void'(ret_cyc.pop_front());
        rdata  = word_of(ret_addr.pop_front());
        rvalid = 1'b1;
        if (m_busy) begin
          m_returned++;
          if (m_returned == m_len) done_next = 1;
        end
      end else begin
        rvalid = 1'b0;
        rdata  = '0;
      end
      if (start && !m_busy) begin
        m_busy = 1; m_addr = base; m_stride = stride;
        m_len = (vlen == 0 || vlen > MAXV) ? MAXV : int'(vlen);
        m_issued = 0; m_returned = 0;
      end
    end
  end

  task automatic readback(input string tag);
    for (int i = 0; i < m_len; i++) begin
      @(posedge clk); #1; rd_idx = 6'(i);
      #2; chk(rd_data, exp_data[i], tag);
    end
  endtask

  // intr_at > 0: pulse start with other operands that many cycles into the load
  task automatic run_load(input logic [15:0] b, input logic [15:0] s, input logic [6:0] l,
                          input int intr_at, input string tag);
    @(posedge clk); #1; start = 1; base = b; stride = s; vlen = l;
    @(posedge clk); #1; start = 0;
    if (intr_at > 0) begin
      repeat (intr_at) @(posedge clk);
      #1; start = 1; base = 16'hBEEF; stride = 16'd7; vlen = 7'd3;
      @(posedge clk); #1; start = 0;
    end
    while (m_busy) @(posedge clk);
    readback(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    #2;
    chk(ready, 1, "R1 ready after reset");
    chk(req, 0, "R1 no request after reset");
    chk(done, 0, "R1 no done after reset");
    run_load(16'h0010, 16'd1, 7'd20, 0, "R6 unit stride slots");       // R5 streaming
    run_load(16'h0100, 16'd2, 7'd24, 0, "R6 stride 2 slots");          // R4 bank revisit stalls
    run_load(16'h0203, 16'd16, 7'd4, 0, "R4 same bank slots");         // R4 one bank only
    run_load(16'h1234, 16'd0, 7'd5, 0, "R9 zero stride slots");        // R9
    run_load(16'hFFF0, 16'd5, 7'd10, 0, "R10 wrap slots");             // R10
    run_load(16'h0040, 16'd3, 7'd0, 0, "R8 zero length slots");        // R8
    chk(m_len, MAXV, "R8 length 0 element count");
    run_load(16'h0800, 16'd1, 7'd100, 0, "R8 over length slots");      // R8
    run_load(16'h0300, 16'd1, 7'd12, 5, "R2 ignored start slots");     // R2
    run_load(16'h0500, 16'd17, 7'd1, 0, "R7 single element slots");    // R7
    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=finish", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule